// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator for a Card Host Controller

This block gathers interrupt events from a removable-card interface into one interrupt line. Each event arrives as a single-cycle pulse and is latched into a local pending register. A local mask register picks which pending events form this controller's request. That request, together with a request level from a sibling controller, feeds a small global pending register. Two separate gates sit on the global register: one decides which global bits count as enabled, and the other decides which may signal the output. The output line is the registered OR of the global bits that pass both gates.

Software uses a plain register port with a write strobe, a word address, write data and a combinational read-back. Pending bits at both levels clear when a 1 is written to them. The mask and gate registers are plain read/write, so software changes them by reading, editing and writing back. The usual bring-up order is to clear stale local events first and only then unmask them. The block is built so that this order never produces a stray pulse on the output.

Top module: `cf_irq_aggregator`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: A pulse on `evt_i` bit k sets local pending bit k on the next clock edge, whether the bit is masked or not, for the implemented positions 0, 1, 2, 3, 8, 9, 10 and 11. These are card detect, status change, memory mode, I/O mode, true-IDE, transfer error, buffer ready and transfer done. Bits 4 to 7 are not implemented: they always read 0, and pulses on them have no effect.
- R3: A write to word address 0 (local pending) clears each bit whose write-data bit is 1 and leaves bits written as 0 unchanged.
- R4: If an event pulse and a clearing write hit the same local pending bit in the same cycle, the bit stays set.
- R5: Word address 1 is the local mask. It is read/write, stores only the implemented positions of R2, and reads back 0 in bits 4 to 7.
- R6: Global pending bit 0 (word address 2) becomes set one edge after any local pending bit is set while its mask bit is set.
- R7: Global pending bit 1 becomes set one edge after a cycle in which `peer_req_i` is high. Either global bit clears when a 1 is written to it at word address 2.
- R8: `irq_o` is high exactly one edge after a cycle in which some global pending bit is set and the matching bits of both the status gate (word address 3) and the signal gate (word address 4) are set. Global bit positions are 0 for this controller and 1 for the sibling.
- R9: If either gate bit is clear, the matching global bit cannot raise `irq_o`.
- R10: Clearing a local pending bit and only then unmasking it never drives `irq_o` high.
- R11: A global pending bit whose source request is still present stays set through a clearing write, because the new request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | LOC_W (12) | Single-cycle event pulses from the card interface |
| peer_req_i | input | 1 | Request level from the sibling controller |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (3) | Register word address |
| reg_wdata_i | input | LOC_W (12) | Register write data |
| reg_rdata_o | output | LOC_W (12) | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt line |

## Verification
A local pending bit that is stuck or lost shows up on the very next read of address 0. It also shows up two edges later in global bit 0 and three edges later on `irq_o`, so the bench samples each of those points on its exact cycle. A wrong priority between set and clear shows up as a pending bit that reads 0 right after a collision, or as a global bit that drops while its source is still active. A gate that is ignored shows up as `irq_o` rising one edge after a global bit sets while the other gate is closed.

// File: rtl/cfirq_pkg.sv
package cfirq_pkg;
    localparam int LOC_W_DEF  = 12;
    localparam int GLB_W      = 2;
    localparam int ADDR_W_DEF = 3;
    localparam logic [LOC_W_DEF-1:0] LOC_IMPL_DEF = 12'hF0F;

    localparam int OFF_LPEND = 0;
    localparam int OFF_LMASK = 1;
    localparam int OFF_GPEND = 2;
    localparam int OFF_GSTEN = 3;
    localparam int OFF_GSGEN = 4;

    typedef struct packed {
        logic irq;
    } out_state_t;
endpackage

// File: rtl/cfirq_w1c_bank.sv
module cfirq_w1c_bank #(
    parameter int           W    = 12,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pend_d, pend_q;

    // new events take priority over a clear in the same cycle
    always_comb begin
        pend_d = ((pend_q & ~clr_i) | set_i) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign q_o = pend_q;
endmodule

// File: rtl/cfirq_rw_bank.sv
module cfirq_rw_bank #(
    parameter int           W    = 12,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (we_i) val_d = wdata_i & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign q_o = val_q;
endmodule

// File: rtl/cf_irq_aggregator.sv
module cf_irq_aggregator
    import cfirq_pkg::*;
#(
    parameter int               LOC_W    = LOC_W_DEF,
    parameter logic [LOC_W-1:0] LOC_IMPL = LOC_IMPL_DEF,
    parameter int               ADDR_W   = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOC_W-1:0]  evt_i,
    input  logic              peer_req_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [LOC_W-1:0]  reg_wdata_i,
    output logic [LOC_W-1:0]  reg_rdata_o,
    output logic              irq_o
);
    localparam int NGATE = 2;

    logic [LOC_W-1:0] lsts_q, len_q, lclr;
    logic [GLB_W-1:0] gsts_q, gsen_q, gsig_q, gclr, gset;
    logic [GLB_W-1:0] gate_q [NGATE];
    logic             we_lpend, we_lmask, we_gpend;
    logic             local_req;
    out_state_t       st_d, st_q;

    assign we_lpend = reg_we_i && (reg_addr_i == ADDR_W'(OFF_LPEND));
    assign we_lmask = reg_we_i && (reg_addr_i == ADDR_W'(OFF_LMASK));
    assign we_gpend = reg_we_i && (reg_addr_i == ADDR_W'(OFF_GPEND));

    assign lclr = we_lpend ? reg_wdata_i : '0;
    assign gclr = we_gpend ? reg_wdata_i[GLB_W-1:0] : '0;

    cfirq_w1c_bank #(.W(LOC_W), .IMPL(LOC_IMPL)) u_lpend (
        .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(lclr), .q_o(lsts_q)
    );

    cfirq_rw_bank #(.W(LOC_W), .IMPL(LOC_IMPL)) u_lmask (
        .clk(clk), .rst_n(rst_n), .we_i(we_lmask), .wdata_i(reg_wdata_i), .q_o(len_q)
    );

    assign local_req = |(lsts_q & len_q);
    assign gset      = {peer_req_i, local_req};

    cfirq_w1c_bank #(.W(GLB_W), .IMPL({GLB_W{1'b1}})) u_gpend (
        .clk(clk), .rst_n(rst_n), .set_i(gset), .clr_i(gclr), .q_o(gsts_q)
    );

    // status gate at OFF_GSTEN, signal gate at OFF_GSGEN
    for (genvar g = 0; g < NGATE; g++) begin : g_gate
        logic we_gate;
        assign we_gate = reg_we_i && (reg_addr_i == ADDR_W'(OFF_GSTEN + g));
        cfirq_rw_bank #(.W(GLB_W), .IMPL({GLB_W{1'b1}})) u_gate (
            .clk(clk), .rst_n(rst_n), .we_i(we_gate),
            .wdata_i(reg_wdata_i[GLB_W-1:0]), .q_o(gate_q[g])
        );
    end

    assign gsen_q = gate_q[0];
    assign gsig_q = gate_q[1];

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(gsts_q & gsen_q & gsig_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_W'(OFF_LPEND): reg_rdata_o = lsts_q;
            ADDR_W'(OFF_LMASK): reg_rdata_o = len_q;
            ADDR_W'(OFF_GPEND): reg_rdata_o[GLB_W-1:0] = gsts_q;
            ADDR_W'(OFF_GSTEN): reg_rdata_o[GLB_W-1:0] = gsen_q;
            ADDR_W'(OFF_GSGEN): reg_rdata_o[GLB_W-1:0] = gsig_q;
            default:            reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/cfirq_checker.sv
module cfirq_checker
    import cfirq_pkg::*;
#(
    parameter int               LOC_W    = LOC_W_DEF,
    parameter logic [LOC_W-1:0] LOC_IMPL = LOC_IMPL_DEF,
    parameter int               ADDR_W   = ADDR_W_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LOC_W-1:0]  evt_i,
    input logic              peer_req_i,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [LOC_W-1:0]  reg_wdata_i,
    input logic [LOC_W-1:0]  lsts,
    input logic [LOC_W-1:0]  len,
    input logic [GLB_W-1:0]  gsts,
    input logic [GLB_W-1:0]  gsen,
    input logic [GLB_W-1:0]  gsig,
    input logic              irq_o
);
    // R2 and R4: an implemented event is pending on the next edge, even when a clear hits it
    p_event_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & LOC_IMPL)) |=> ((lsts & $past(evt_i & LOC_IMPL)) == $past(evt_i & LOC_IMPL)));

    // R3: written ones clear when no event collides
    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == ADDR_W'(OFF_LPEND) && evt_i == '0)
        |=> ((lsts & $past(reg_wdata_i)) == '0));

    // R5: mask write lands masked to implemented bits
    p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == ADDR_W'(OFF_LMASK)) |=> (len == ($past(reg_wdata_i) & LOC_IMPL)));

    // R6: an unmasked local pending bit raises global bit 0
    p_local_to_global_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lsts & len)) |=> gsts[0]);

    // R7: sibling request raises global bit 1
    p_peer_to_global_r7: assert property (@(posedge clk) disable iff (!rst_n)
        peer_req_i |=> gsts[1]);

    // R8 and R9: the line rises only from a doubly gated pending bit
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(gsts & gsen & gsig)) |=> irq_o);
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(gsts & gsen & gsig))) |=> !irq_o);
endmodule

bind cf_irq_aggregator cfirq_checker #(
    .LOC_W(LOC_W), .LOC_IMPL(LOC_IMPL), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .peer_req_i(peer_req_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .lsts(lsts_q), .len(len_q), .gsts(gsts_q), .gsen(gsen_q), .gsig(gsig_q),
    .irq_o(irq_o)
);

// File: tb/cf_irq_aggregator_test.sv
`timescale 1ns/1ps
module cf_irq_aggregator_test;
    localparam int LW = 12;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] evt = '0;
    logic          peer = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [LW-1:0] wdata = '0;
    logic [LW-1:0] rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cf_irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .peer_req_i(peer),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [LW-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [LW-1:0] exp);
        @(negedge clk);
        addr = AW'(a);
        #1 check(req, rdata, exp);
    endtask

    task automatic pulse(input logic [LW-1:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 5; a++) rd_chk("R1", a, '0);
        check("R1", LW'(irq), '0);
    endtask

    task automatic t_latch;
        pulse(12'hFFF);
        rd_chk("R2", 0, 12'hF0F);   // reserved bits 4..7 never set
        rd_chk("R2", 2, '0);        // unmasked: no global request
        check("R2", LW'(irq), '0);
    endtask

    task automatic t_w1c;
        wr(0, 12'h00F);
        rd_chk("R3", 0, 12'hF00);
        wr(0, 12'h000);
        rd_chk("R3", 0, 12'hF00);
        wr(0, 12'hF00);
        rd_chk("R3", 0, 12'h000);
    endtask

    task automatic t_collision;
        pulse(12'h200);
        @(negedge clk);
        we = 1'b1; addr = AW'(0); wdata = 12'h200; evt = 12'h200;
        @(negedge clk);
        we = 1'b0; wdata = '0; evt = '0;
        rd_chk("R4", 0, 12'h200);
        wr(0, 12'h200);
        rd_chk("R4", 0, 12'h000);
    endtask

    task automatic t_mask_rw;
        wr(1, 12'hFFF);
        rd_chk("R5", 1, 12'hF0F);
        wr(1, 12'h000);
        rd_chk("R5", 1, 12'h000);
    endtask

    task automatic t_clear_then_enable;
        wr(3, 12'h001);
        wr(4, 12'h001);
        pulse(12'h001);             // stale event, masked
        wr(0, 12'h001);             // clear first
        wr(1, 12'h001);             // then unmask
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R10", LW'(irq), '0);
        end
        rd_chk("R10", 2, '0);
        // fresh event: pending at edge 1, global at edge 2, line at edge 3
        pulse(12'h001);
        addr = AW'(2);
        @(negedge clk);
        #1 check("R6", rdata, 12'h001);
        check("R8", LW'(irq), '0);
        @(negedge clk);
        check("R8", LW'(irq), 12'h001);
    endtask

    task automatic t_global_sticky;
        wr(2, 12'h001);             // local source still pending
        rd_chk("R11", 2, 12'h001);
        wr(0, 12'h001);             // drop the source
        wr(2, 12'h001);             // now the clear takes
        check("R8", LW'(irq), 12'h001);
        addr = AW'(2);
        #1 check("R11", rdata, '0);
        @(negedge clk);
        check("R8", LW'(irq), '0);
        wr(1, 12'h000);
    endtask

    task automatic t_peer;
        wr(3, 12'h003);
        wr(4, 12'h001);             // signal gate closed for bit 1
        @(negedge clk);
        peer = 1'b1;
        @(negedge clk);
        peer = 1'b0;
        rd_chk("R7", 2, 12'h002);
        check("R9", LW'(irq), '0);
        wr(4, 12'h003);
        check("R9", LW'(irq), '0);  // gate opened this edge, line next edge
        @(negedge clk);
        check("R8", LW'(irq), 12'h001);
        wr(3, 12'h001);             // status gate closed for bit 1
        @(negedge clk);
        check("R9", LW'(irq), '0);
        wr(2, 12'h002);
        rd_chk("R7", 2, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_w1c();
        t_collision();
        t_mask_rw();
        t_clear_then_enable();
        t_global_sticky();
        t_peer();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule